// File: doc/BRIEF.md
# Method-Indexed Command Register File

This block holds the state registers of a graphics command front end. A command stream writes one 32-bit word per cycle to a register chosen by its method index. A consumer reads any register through a combinational port, and watches a single dirty flag that says whether the vertex-format window has changed since it last looked.

Reset first clears every word, then loads the registers that need a working value before software sets them. These are the viewport depth ranges, the stencil state for both faces, and the shared and per-target blend state. A write is committed only when its value differs from the stored word. A committed write that lands inside the vertex-format window raises the dirty flag. The consumer lowers the flag with a one-cycle clear strobe.

Top module: `cmd_regfile`

## Requirements
- R1: After reset, every register outside the viewport, stencil and blend groups reads 0.
- R2: After reset, viewport v (0..15) holds 0x00000000 at word 0x100+2v (near) and 0x3F800000 at word 0x101+2v (far).
- R3: After reset, the stencil group at 0x200 holds: words +0..+2 (front fail/zfail/zpass) and +6..+8 (back) = 1 (keep); words +3 and +9 (compare function) = 8 (always); words +4, +5, +10, +11 (compare mask and write mask) = 0xFFFFFFFF; word +12 (two-sided enable) = 1.
- R4: After reset, the shared blend group at 0x300 and each target slot t (0..7) at 0x380+8t hold, in words +0..+5: colour equation 1 (add), colour source 2 (one), colour destination 1 (zero), alpha equation 1, alpha source 2, alpha destination 1. Words +6 and +7 of a target slot stay 0.
- R5: The read port returns the addressed word combinationally. A committed write is visible on the cycle after its clock edge.
- R6: A write whose value equals the stored word leaves the word unchanged and does not set the dirty flag.
- R7: A write that changes a word with index in [0x458, 0x478) sets the dirty flag on the next cycle. A changing write outside that window, including 0x457 and 0x478, leaves the flag as it was.
- R8: The dirty flag reads 1 after reset.
- R9: A clear strobe lowers the dirty flag on the next cycle. When a set condition and the strobe share a cycle, the flag ends up 1.
- R10: While the write enable is low, the write index and data have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write request this cycle |
| wr_idx_i | input | 11 | Method index of the write |
| wr_data_i | input | 32 | Value to write |
| rd_idx_i | input | 11 | Method index to read |
| rd_data_o | output | 32 | Word at rd_idx_i (combinational) |
| dirty_clr_i | input | 1 | One-cycle strobe that clears the dirty flag |
| dirty_o | output | 1 | Vertex-format dirty flag |

## Verification
The assertions assume that the register count is a power of two, so every index is in range. They also assume that the reset and layout parameters place the viewport, stencil, blend and target groups without overlap, with a target stride of at least six words. The stimulus only drives indices of the default 11-bit width. It treats the clear strobe as free-running, so it is raised both alone and together with window writes. Random writes are kept to a narrow band around the watched window and draw from a four-value set. This makes equal-value writes, edge indices and set/clear collisions frequent.

// File: rtl/cmd_regfile_pkg.sv
// Package: shared encodings and the reset-value function of the command
// register file. Assumes group bases passed in do not overlap.
package cmd_regfile_pkg;

    typedef logic [31:0] word_t;

    // Encodings loaded by reset
    localparam word_t STENCIL_KEEP   = 32'd1;
    localparam word_t CMP_ALWAYS     = 32'd8;
    localparam word_t BLEND_EQ_ADD   = 32'd1;
    localparam word_t BLEND_F_ONE    = 32'd2;
    localparam word_t BLEND_F_ZERO   = 32'd1;
    localparam word_t DEPTH_NEAR     = 32'h0000_0000;
    localparam word_t DEPTH_FAR      = 32'h3F80_0000;
    localparam word_t ALL_ONES       = 32'hFFFF_FFFF;

    localparam int STENCIL_WORDS = 13;
    localparam int BLEND_WORDS   = 6;

    // Reset value of word k inside a six-word blend group.
    function automatic word_t blend_word(input int k);
        case (k)
            0, 3:    blend_word = BLEND_EQ_ADD;
            1, 4:    blend_word = BLEND_F_ONE;
            2, 5:    blend_word = BLEND_F_ZERO;
            default: blend_word = '0;
        endcase
    endfunction

    // Reset value of word k inside the two-face stencil group.
    function automatic word_t stencil_word(input int k);
        case (k)
            0, 1, 2, 6, 7, 8: stencil_word = STENCIL_KEEP;
            3, 9:             stencil_word = CMP_ALWAYS;
            4, 5, 10, 11:     stencil_word = ALL_ONES;
            12:               stencil_word = 32'd1;
            default:          stencil_word = '0;
        endcase
    endfunction

    // Reset value of register idx under the given layout; zero elsewhere.
    function automatic word_t reset_word(
        input int idx,
        input int vp_base, input int vp_count,
        input int stc_base,
        input int blend_base,
        input int tgt_base, input int tgt_count, input int tgt_stride
    );
        word_t w;
        w = '0;
        if (idx >= vp_base && idx < vp_base + 2 * vp_count)
            w = ((idx - vp_base) % 2 == 1) ? DEPTH_FAR : DEPTH_NEAR;
        else if (idx >= stc_base && idx < stc_base + STENCIL_WORDS)
            w = stencil_word(idx - stc_base);
        else if (idx >= blend_base && idx < blend_base + BLEND_WORDS)
            w = blend_word(idx - blend_base);
        else if (idx >= tgt_base && idx < tgt_base + tgt_count * tgt_stride)
            w = blend_word((idx - tgt_base) % tgt_stride);
        return w;
    endfunction

endpackage

// File: rtl/cmd_regfile_store.sv
// Module: register storage. Holds NUM_REGS words, loads layout defaults
// on reset, commits a word when told to, and serves two combinational
// read ports (consumer read and write-side compare).
// Assumes NUM_REGS is a power of two so every index is in range.
module cmd_regfile_store
    import cmd_regfile_pkg::*;
#(
    parameter int NUM_REGS   = 2048,
    parameter int VP_BASE    = 'h100,
    parameter int VP_COUNT   = 16,
    parameter int STC_BASE   = 'h200,
    parameter int BLEND_BASE = 'h300,
    parameter int TGT_BASE   = 'h380,
    parameter int TGT_COUNT  = 8,
    parameter int TGT_STRIDE = 8,
    localparam int ADDR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] wr_idx_i,
    input  word_t             wr_data_i,
    input  logic [ADDR_W-1:0] rd_idx_i,
    output word_t             rd_data_o,
    output word_t             cur_data_o
);

    word_t regs [NUM_REGS];

    // Load defaults on reset, otherwise commit the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs[i] <= reset_word(i, VP_BASE, VP_COUNT, STC_BASE,
                                      BLEND_BASE, TGT_BASE, TGT_COUNT,
                                      TGT_STRIDE);
        end else if (commit_i) begin
            regs[wr_idx_i] <= wr_data_i;
        end
    end

    // Consumer read port.
    assign rd_data_o  = regs[rd_idx_i];
    // Write-side read of the currently stored word for change detection.
    assign cur_data_o = regs[wr_idx_i];

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> regs[$past(wr_idx_i)] == $past(wr_data_i));

    // R10
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> regs[$past(wr_idx_i)] == $past(regs[wr_idx_i]));

endmodule

// File: rtl/cmd_regfile_change.sv
// Module: change detector. Accepts a write only when its value differs
// from the stored word and flags accepted writes inside the watched window.
// Assumes cur_data_i is the stored word at wr_idx_i in the same cycle.
module cmd_regfile_change
    import cmd_regfile_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int WIN_BASE = 'h458,
    parameter int WIN_LEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_idx_i,
    input  word_t             wr_data_i,
    input  word_t             cur_data_i,
    output logic              commit_o,
    output logic              win_hit_o
);

    logic in_window;

    // Decide whether the index lies in the watched window.
    always_comb begin
        in_window = (int'(wr_idx_i) >= WIN_BASE) &&
                    (int'(wr_idx_i) <  WIN_BASE + WIN_LEN);
    end

    // Accept only value-changing writes; mark those inside the window.
    always_comb begin
        commit_o  = wr_en_i && (cur_data_i != wr_data_i);
        win_hit_o = commit_o && in_window;
    end

    // R6
    equal_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && cur_data_i == wr_data_i) |-> !win_hit_o);

endmodule

// File: rtl/cmd_regfile_dirty.sv
// Module: dirty flag. Sets on a window hit, clears on a strobe, set wins
// a tie. Reads 1 after reset so the first consumer pass always reloads.
module cmd_regfile_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic dirty_o
);

    logic dirty_q;

    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      dirty_q <= 1'b1;
        else if (set_i)  dirty_q <= 1'b1;
        else if (clr_i)  dirty_q <= 1'b0;
    end

    assign dirty_o = dirty_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> dirty_q);

    // R9
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !dirty_q);

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !dirty_q) |=> !dirty_q);

    // R8
    reset_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dirty_q);

endmodule

// File: rtl/cmd_regfile.sv
// Module: top of the command register file. Ties together storage,
// change detection and the dirty flag. Assumes one write per cycle.
module cmd_regfile
    import cmd_regfile_pkg::*;
#(
    parameter int NUM_REGS   = 2048,
    parameter int VP_BASE    = 'h100,
    parameter int VP_COUNT   = 16,
    parameter int STC_BASE   = 'h200,
    parameter int BLEND_BASE = 'h300,
    parameter int TGT_BASE   = 'h380,
    parameter int TGT_COUNT  = 8,
    parameter int TGT_STRIDE = 8,
    parameter int WIN_BASE   = 'h458,
    parameter int WIN_LEN    = 32,
    localparam int ADDR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_idx_i,
    input  logic [31:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_idx_i,
    output logic [31:0]       rd_data_o,
    input  logic              dirty_clr_i,
    output logic              dirty_o
);

    word_t cur_word;
    logic  commit;
    logic  win_hit;

    cmd_regfile_store #(
        .NUM_REGS   (NUM_REGS),
        .VP_BASE    (VP_BASE),
        .VP_COUNT   (VP_COUNT),
        .STC_BASE   (STC_BASE),
        .BLEND_BASE (BLEND_BASE),
        .TGT_BASE   (TGT_BASE),
        .TGT_COUNT  (TGT_COUNT),
        .TGT_STRIDE (TGT_STRIDE)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i),
        .rd_idx_i   (rd_idx_i),
        .rd_data_o  (rd_data_o),
        .cur_data_o (cur_word)
    );

    cmd_regfile_change #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LEN  (WIN_LEN)
    ) u_change (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i),
        .cur_data_i (cur_word),
        .commit_o   (commit),
        .win_hit_o  (win_hit)
    );

    cmd_regfile_dirty u_dirty (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (win_hit),
        .clr_i   (dirty_clr_i),
        .dirty_o (dirty_o)
    );

endmodule

// File: tb/cmd_regfile_test.sv
`timescale 1ns/1ps
module cmd_regfile_test;

    localparam int N   = 2048;
    localparam int AW  = 11;
    localparam int WB  = 'h458;
    localparam int WL  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_idx = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_idx = '0;
    logic [31:0]   rd_data;
    logic          dclr = 1'b0;
    logic          dirty;

    int  total = 0;
    int  fails = 0;
    bit  finished = 0;

    logic [31:0] model [N];
    bit          model_dirty;

    always #10 clk = ~clk;

    cmd_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .dirty_clr_i(dclr), .dirty_o(dirty)
    );

    // Expected reset value, written from the requirement text.
    function automatic logic [31:0] expect_reset(input int i);
        int k;
        if (i >= 'h100 && i < 'h120) return (i[0]) ? 32'h3F800000 : 32'h0;
        if (i >= 'h200 && i <= 'h20C) begin
            k = i - 'h200;
            if (k == 3 || k == 9) return 32'd8;
            if (k == 4 || k == 5 || k == 10 || k == 11) return 32'hFFFFFFFF;
            return 32'd1;
        end
        if (i >= 'h300 && i < 'h306) k = i - 'h300;
        else if (i >= 'h380 && i < 'h3C0) k = (i - 'h380) % 8;
        else return 32'h0;
        if (k == 1 || k == 4) return 32'd2;
        if (k >= 6) return 32'h0;
        return 32'd1;
    endfunction

    function automatic string region_tag(input int i);
        if (i >= 'h100 && i < 'h120) return "R2";
        if (i >= 'h200 && i <= 'h20C) return "R3";
        if ((i >= 'h300 && i < 'h306) || (i >= 'h380 && i < 'h3C0)) return "R4";
        return "R1";
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, compare outputs, update model at rising edge.
    task automatic cycle(input bit en, input int idx, input logic [31:0] data,
                         input bit clr, input int ridx,
                         input string dtag, input string ftag);
        @(negedge clk);
        wr_en = en; wr_idx = idx[AW-1:0]; wr_data = data;
        dclr = clr; rd_idx = ridx[AW-1:0];
        #1;
        check(rd_data === model[ridx], dtag, rd_data, model[ridx]);
        check(dirty === model_dirty, ftag, {31'b0, dirty}, {31'b0, model_dirty});
        @(posedge clk);
        if (en && model[idx] != data) begin
            model[idx] = data;
            if (clr) model_dirty = 0;
            if (idx >= WB && idx < WB + WL) model_dirty = 1;
        end else if (clr) begin
            model_dirty = 0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        for (int i = 0; i < N; i++) model[i] = expect_reset(i);
        model_dirty = 1;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R8: sweep the whole file after reset
        for (int i = 0; i < N; i++)
            cycle(0, 0, 0, 0, i, region_tag(i), "R8");

        // R9: clear strobe alone
        cycle(0, 0, 0, 1, 0, "R1", "R8");
        // R5: write outside window, R9 flag now low
        cycle(1, 'h010, 32'h1234, 0, 'h010, "R1", "R9");
        cycle(0, 0, 0, 0, 'h010, "R5", "R7");
        // R6: equal write inside window
        cycle(1, 'h458, 32'h0, 0, 'h458, "R6", "R9");
        cycle(0, 0, 0, 0, 'h458, "R6", "R6");
        // R7: last word of window
        cycle(1, 'h477, 32'd5, 0, 'h477, "R5", "R6");
        cycle(0, 0, 0, 0, 'h477, "R5", "R7");
        cycle(0, 0, 0, 1, 'h477, "R5", "R7");
        // R7: first word past window and word before
        cycle(1, 'h478, 32'd7, 0, 'h478, "R5", "R9");
        cycle(1, 'h457, 32'd9, 0, 'h478, "R5", "R7");
        cycle(0, 0, 0, 0, 'h457, "R5", "R7");
        // R9: set and clear in same cycle
        cycle(1, 'h460, 32'd3, 1, 'h460, "R5", "R7");
        cycle(0, 0, 0, 0, 'h460, "R5", "R9");
        // R10: enable low
        cycle(0, 'h460, 32'hDEAD, 0, 'h460, "R10", "R9");
        cycle(0, 0, 0, 1, 'h460, "R10", "R10");
        // R6: equal write to a defaulted stencil mask
        cycle(1, 'h204, 32'hFFFFFFFF, 0, 'h204, "R3", "R9");
        cycle(0, 0, 0, 0, 'h204, "R6", "R6");

        // R5 R7 R9: random stream around the window
        for (int n = 0; n < 400; n++)
            cycle(($urandom % 4) != 0, 'h440 + ($urandom % 'h50),
                  32'($urandom % 4), ($urandom % 4) == 0,
                  'h440 + ($urandom % 'h50), "R5", "R7");
        cycle(0, 0, 0, 0, 'h458, "R5", "R7");

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule